// File: doc/BRIEF.md
# Ring Switch Node with Prioritised Injection

This block is one stop on a one-way ring of switches that carries 42-bit flits. Each flit arrives from the upstream neighbour with a request and an acknowledge. The node reads the destination field in the flit header. If the destination is this node, it hands the flit to the local processing core. Otherwise it passes the flit on to the downstream neighbour through a single output register. That register keeps its request raised until the downstream switch acknowledges it.

Two local sources can also place flits on the ring: the processing core and a 2D mesh router. Mesh traffic is first written into one of two small virtual-channel FIFOs, and the mesh router picks the channel. The output slot goes to the sources in a fixed order:

1. a flit passing through from upstream;
2. the two mesh FIFOs, which take turns round-robin;
3. the core, only when nothing else wants the slot.

Because traffic already on the ring always wins, flits in flight move on with the least delay, and new traffic enters only when there is room.

Top module: `ring_switch_node`

## Requirements
- R1: After reset, ring_out_req and eject_valid are low and both mesh FIFOs are empty, so a mesh request to either channel is acknowledged.
- R2: While ring_out_req is high and ring_out_ack is low, ring_out_req stays high and ring_out_data does not change. A transfer completes on a clock edge where both are high.
- R3: The destination of a flit is its bits [41:38]. A ring flit whose destination equals NODE_ID is acknowledged in the same cycle whatever the output state. It appears on eject_valid/eject_data in the next cycle for one cycle and is never placed on ring_out.
- R4: A ring flit for another node is acknowledged in the same cycle only when the output register is free (empty, or being acknowledged at this edge), and it appears on ring_out_data in the next cycle.
- R5: When the output register is free, a passing ring flit takes it ahead of both mesh FIFOs and the core; then core_inj_ack stays low and nothing leaves the FIFOs.
- R6: mesh_vc selects channel 0 or 1. mesh_ack is high when mesh_req is high and the selected FIFO holds fewer than 4 flits. Each FIFO delivers its flits in arrival order.
- R7: The mesh FIFOs win the output slot whenever it is free and no ring flit is passing. When both hold flits they are served alternately, starting with channel 0 after reset. A single non-empty channel is served on every grant.
- R8: core_inj_ack is high only when the output register is free, no ring flit is passing and both FIFOs are empty. An injected core flit is always forwarded downstream, whatever its destination.
- R9: With ring_out_ack held high, the node can send one flit downstream on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_in_req | input | 1 | Upstream neighbour offers a flit |
| ring_in_data | input | 42 | Flit from upstream |
| ring_in_ack | output | 1 | Flit from upstream accepted this cycle |
| ring_out_req | output | 1 | Flit offered to downstream neighbour |
| ring_out_data | output | 42 | Flit to downstream |
| ring_out_ack | input | 1 | Downstream accepts the offered flit |
| core_inj_req | input | 1 | Local core offers a flit |
| core_inj_data | input | 42 | Flit from the local core |
| core_inj_ack | output | 1 | Core flit accepted this cycle |
| mesh_req | input | 1 | Mesh router offers a flit |
| mesh_vc | input | 1 | Target mesh FIFO (0 or 1) |
| mesh_data | input | 42 | Flit from the mesh router |
| mesh_ack | output | 1 | Mesh flit stored this cycle |
| eject_valid | output | 1 | Flit delivered to the local core |
| eject_data | output | 42 | Delivered flit |

## Verification
If the output register is corrupted, it shows up on ring_out_data on the next cycle. It also shows up if the register drops a held flit, which appears as a stall broken one edge after a cycle with no acknowledge. A wrong FIFO pointer or count shows up as mesh_ack being wrong on the fourth or fifth push, or as flits leaving in the wrong order once the output drains. A stuck or mis-advanced round-robin pointer breaks the strict alternation of the two channels within two flits. A priority fault shows up as core_inj_ack rising in the same cycle as a passing ring flit or while a FIFO still holds data.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_RING = 2'd1,
    SRC_VC   = 2'd2,
    SRC_CORE = 2'd3
  } rs_src_e;
endpackage

// File: rtl/rs_vc_fifo.sv
module rs_vc_fifo #(
  parameter int W     = 42,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_nxt, rd_ptr, rd_ptr_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_push, do_pop;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = cnt;
    if (do_push) wr_ptr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (do_push && !do_pop)      cnt_nxt = cnt + 1'b1;
    else if (do_pop && !do_push) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/rs_rr_arb.sv
module rs_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last, last_nxt;

  always_comb begin
    int idx;
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int o = 1; o <= N; o++) begin
      idx = (int'(last) + o) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    last_nxt = last;
    if (adv) begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) last_nxt = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IW'(N - 1);
    else        last <= last_nxt;
  end
endmodule

// File: rtl/ring_switch_node.sv
module ring_switch_node
  import rs_pkg::*;
#(
  parameter int FLIT_W   = 42,
  parameter int DEST_W   = 4,
  parameter int NODE_ID  = 5,
  parameter int NUM_VC   = 2,
  parameter int VC_DEPTH = 4,
  localparam int VSW     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_in_req,
  input  logic [FLIT_W-1:0] ring_in_data,
  output logic              ring_in_ack,
  output logic              ring_out_req,
  output logic [FLIT_W-1:0] ring_out_data,
  input  logic              ring_out_ack,
  input  logic              core_inj_req,
  input  logic [FLIT_W-1:0] core_inj_data,
  output logic              core_inj_ack,
  input  logic              mesh_req,
  input  logic [VSW-1:0]    mesh_vc,
  input  logic [FLIT_W-1:0] mesh_data,
  output logic              mesh_ack,
  output logic              eject_valid,
  output logic [FLIT_W-1:0] eject_data
);
  localparam int DEST_LSB = FLIT_W - DEST_W;

  logic [NUM_VC-1:0] vc_full, vc_empty, vc_push, vc_pop, vc_gnt;
  logic [FLIT_W-1:0] vc_rd_data [NUM_VC];
  logic [FLIT_W-1:0] vc_sel_data;

  logic              ring_is_local, out_free, fwd_take, vc_take, core_take;
  rs_src_e           src_sel;
  logic              out_vld, out_vld_nxt, out_load;
  logic [FLIT_W-1:0] out_flit, out_flit_nxt;
  logic              ej_vld, ej_vld_nxt;
  logic [FLIT_W-1:0] ej_flit;

  // Mesh ingress into the selected virtual channel
  assign mesh_ack = mesh_req && !vc_full[mesh_vc];

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assign vc_push[v] = mesh_ack && (mesh_vc == VSW'(v));
    rs_vc_fifo #(.W(FLIT_W), .DEPTH(VC_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (vc_push[v]),
      .push_data (mesh_data),
      .pop       (vc_pop[v]),
      .pop_data  (vc_rd_data[v]),
      .empty     (vc_empty[v]),
      .full      (vc_full[v])
    );
  end

  rs_rr_arb #(.N(NUM_VC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (~vc_empty),
    .adv   (vc_take),
    .gnt   (vc_gnt)
  );

  // Header decode and slot arbitration
  assign ring_is_local = (ring_in_data[FLIT_W-1:DEST_LSB] == DEST_W'(NODE_ID));
  assign out_free      = !out_vld || ring_out_ack;
  assign fwd_take      = ring_in_req && !ring_is_local && out_free;
  assign vc_take       = out_free && !fwd_take && !(&vc_empty);
  assign core_take     = out_free && !fwd_take && (&vc_empty) && core_inj_req;
  assign vc_pop        = vc_gnt & {NUM_VC{vc_take}};

  assign ring_in_ack   = ring_in_req && (ring_is_local || out_free);
  assign core_inj_ack  = core_take;

  always_comb begin
    vc_sel_data = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (vc_gnt[v]) vc_sel_data = vc_sel_data | vc_rd_data[v];
    end
  end

  always_comb begin
    if (fwd_take)       src_sel = SRC_RING;
    else if (vc_take)   src_sel = SRC_VC;
    else if (core_take) src_sel = SRC_CORE;
    else                src_sel = SRC_IDLE;
  end

  // Output stage next state
  always_comb begin
    out_load     = out_free;
    out_vld_nxt  = out_vld;
    out_flit_nxt = out_flit;
    if (out_load) begin
      out_vld_nxt = (src_sel != SRC_IDLE);
      unique case (src_sel)
        SRC_RING: out_flit_nxt = ring_in_data;
        SRC_VC:   out_flit_nxt = vc_sel_data;
        SRC_CORE: out_flit_nxt = core_inj_data;
        default:  out_flit_nxt = out_flit;
      endcase
    end
  end

  assign ej_vld_nxt = ring_in_req && ring_is_local;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      ej_vld  <= 1'b0;
    end else begin
      out_vld <= out_vld_nxt;
      ej_vld  <= ej_vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_flit <= '0;
    else if (out_load) out_flit <= out_flit_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ej_flit <= '0;
    else if (ej_vld_nxt) ej_flit <= ring_in_data;
  end

  assign ring_out_req  = out_vld;
  assign ring_out_data = out_flit;
  assign eject_valid   = ej_vld;
  assign eject_data    = ej_flit;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int FLIT_W  = 42,
  parameter int DEST_W  = 4,
  parameter int NODE_ID = 5,
  parameter int NUM_VC  = 2,
  parameter int VSW     = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ring_in_req,
  input logic [FLIT_W-1:0] ring_in_data,
  input logic              ring_in_ack,
  input logic              ring_out_req,
  input logic [FLIT_W-1:0] ring_out_data,
  input logic              ring_out_ack,
  input logic              core_inj_ack,
  input logic              mesh_req,
  input logic [VSW-1:0]    mesh_vc,
  input logic              mesh_ack,
  input logic              eject_valid,
  input logic [NUM_VC-1:0] vc_full,
  input logic [NUM_VC-1:0] vc_empty,
  input logic [NUM_VC-1:0] vc_pop
);
  logic is_local;
  assign is_local = (ring_in_data[FLIT_W-1:FLIT_W-DEST_W] == DEST_W'(NODE_ID));

  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_req && !ring_out_ack |=> ring_out_req && $stable(ring_out_data));

  a_r3_local_acked: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_req && is_local |-> ring_in_ack);

  a_r3_local_ejects: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_req && is_local |=> eject_valid);

  a_r5_ring_first: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_req && !is_local && ring_in_ack |-> !core_inj_ack && (vc_pop == '0));

  a_r6_no_ack_full: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_req && vc_full[mesh_vc] |-> !mesh_ack);

  a_r7_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_pop));

  a_r8_core_last: assert property (@(posedge clk) disable iff (!rst_n)
    core_inj_ack |-> (&vc_empty));
endmodule

bind ring_switch_node rs_checker #(
  .FLIT_W (FLIT_W),
  .DEST_W (DEST_W),
  .NODE_ID(NODE_ID),
  .NUM_VC (NUM_VC),
  .VSW    (VSW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ring_in_req  (ring_in_req),
  .ring_in_data (ring_in_data),
  .ring_in_ack  (ring_in_ack),
  .ring_out_req (ring_out_req),
  .ring_out_data(ring_out_data),
  .ring_out_ack (ring_out_ack),
  .core_inj_ack (core_inj_ack),
  .mesh_req     (mesh_req),
  .mesh_vc      (mesh_vc),
  .mesh_ack     (mesh_ack),
  .eject_valid  (eject_valid),
  .vc_full      (vc_full),
  .vc_empty     (vc_empty),
  .vc_pop       (vc_pop)
);

// File: tb/ring_switch_node_tb.sv
module ring_switch_node_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW   = 42;
  localparam int NID  = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ring_in_req, ring_in_ack, ring_out_req, ring_out_ack;
  logic [FW-1:0] ring_in_data, ring_out_data, core_inj_data, mesh_data, eject_data;
  logic          core_inj_req, core_inj_ack, mesh_req, mesh_ack, eject_valid;
  logic [0:0]    mesh_vc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_switch_node dut_i (
    .clk(clk), .rst_n(rst_n),
    .ring_in_req(ring_in_req), .ring_in_data(ring_in_data), .ring_in_ack(ring_in_ack),
    .ring_out_req(ring_out_req), .ring_out_data(ring_out_data), .ring_out_ack(ring_out_ack),
    .core_inj_req(core_inj_req), .core_inj_data(core_inj_data), .core_inj_ack(core_inj_ack),
    .mesh_req(mesh_req), .mesh_vc(mesh_vc), .mesh_data(mesh_data), .mesh_ack(mesh_ack),
    .eject_valid(eject_valid), .eject_data(eject_data)
  );

  function automatic logic [FW-1:0] mk(input int dest, input int tag);
    return {4'(dest), 38'(tag * 1021 + 7)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ring_in_req = 0; ring_in_data = '0; ring_out_ack = 0;
    core_inj_req = 0; core_inj_data = '0;
    mesh_req = 0; mesh_vc = '0; mesh_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  // Park one flit in the output register with downstream stalled
  task automatic stall_with(input logic [FW-1:0] f);
    @(negedge clk);
    ring_out_ack = 0; ring_in_req = 1; ring_in_data = f;
    @(posedge clk); #1;
    @(negedge clk) ring_in_req = 0;
  endtask

  task automatic push(input int vc, input logic [FW-1:0] f, input bit exp_ack, input string rq);
    @(negedge clk);
    mesh_req = 1; mesh_vc = 1'(vc); mesh_data = f;
    #4 chk(mesh_ack == exp_ack, rq, 64'(mesh_ack), 64'(exp_ack));
    @(posedge clk); #1;
    @(negedge clk) mesh_req = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] xf, rf, mf, cf;
    do_reset();
    #1;
    // R1 reset state
    chk(ring_out_req == 0, "R1 out_req", 64'(ring_out_req), 0);
    chk(eject_valid == 0, "R1 eject", 64'(eject_valid), 0);
    mesh_req = 1; mesh_vc = 0; #1;
    chk(mesh_ack == 1, "R1 vc0 empty", 64'(mesh_ack), 1);
    mesh_vc = 1; #1;
    chk(mesh_ack == 1, "R1 vc1 empty", 64'(mesh_ack), 1);
    mesh_req = 0;

    // R3/R4/R9 sweep over every destination, downstream always ready
    for (int d = 0; d < 16; d++) begin
      logic [FW-1:0] f;
      f = mk(d, d + 3);
      @(negedge clk);
      ring_out_ack = 1; ring_in_req = 1; ring_in_data = f;
      #4 chk(ring_in_ack == 1, "R4 ring ack free", 64'(ring_in_ack), 1);
      @(posedge clk); #1;
      if (d == NID) begin
        chk(eject_valid == 1 && eject_data == f, "R3 eject", 64'(eject_data), 64'(f));
        chk(ring_out_req == 0, "R3 not forwarded", 64'(ring_out_req), 0);
      end else begin
        chk(ring_out_req == 1 && ring_out_data == f, "R4 forward", 64'(ring_out_data), 64'(f));
        chk(eject_valid == 0, "R3 no eject", 64'(eject_valid), 0);
      end
      @(negedge clk) ring_in_req = 0;
      @(posedge clk); #1;
      chk(eject_valid == 0, "R3 one cycle", 64'(eject_valid), 0);
      chk(ring_out_req == 0, "R9 drained", 64'(ring_out_req), 0);
    end

    // R2 hold under stall, R4 blocked, R3 eject while blocked
    do_reset();
    xf = mk(2, 11);
    stall_with(xf);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      ring_in_req = 1; ring_in_data = mk(9, 40 + k);
      #4 chk(ring_in_ack == 0, "R4 blocked when full", 64'(ring_in_ack), 0);
      @(posedge clk); #1;
      chk(ring_out_req == 1 && ring_out_data == xf, "R2 hold", 64'(ring_out_data), 64'(xf));
    end
    @(negedge clk);
    ring_in_data = mk(NID, 77);
    #4 chk(ring_in_ack == 1, "R3 local ack while full", 64'(ring_in_ack), 1);
    @(posedge clk); #1;
    chk(eject_valid == 1 && eject_data == mk(NID, 77), "R3 eject while full",
        64'(eject_data), 64'(mk(NID, 77)));
    chk(ring_out_data == xf, "R2 hold after eject", 64'(ring_out_data), 64'(xf));
    @(negedge clk) ring_in_req = 0;

    // R6 capacity and R7 alternation, R9 back-to-back drain
    for (int i = 0; i < 4; i++) push(0, mk(1, 100 + i), 1'b1, "R6 vc0 space");
    push(0, mk(1, 199), 1'b0, "R6 vc0 full");
    for (int i = 0; i < 4; i++) push(1, mk(3, 200 + i), 1'b1, "R6 vc1 space");
    push(1, mk(3, 299), 1'b0, "R6 vc1 full");
    @(negedge clk) ring_out_ack = 1;
    for (int k = 0; k < 8; k++) begin
      logic [FW-1:0] e;
      e = (k % 2 == 0) ? mk(1, 100 + k/2) : mk(3, 200 + k/2);
      @(posedge clk); #1;
      chk(ring_out_req == 1 && ring_out_data == e, "R7 alternate order R9",
          64'(ring_out_data), 64'(e));
    end
    @(posedge clk); #1;
    chk(ring_out_req == 0, "R6 full push dropped", 64'(ring_out_req), 0);

    // R5 ring first, R7 single channel, R8 core last
    do_reset();
    xf = mk(2, 12); rf = mk(9, 13); mf = mk(4, 14); cf = mk(NID, 15);
    stall_with(xf);
    push(1, mf, 1'b1, "R6 vc1 push");
    @(negedge clk);
    core_inj_req = 1; core_inj_data = cf;
    ring_in_req = 1; ring_in_data = rf; ring_out_ack = 1;
    #4 chk(ring_in_ack == 1, "R5 ring ack", 64'(ring_in_ack), 1);
    chk(core_inj_ack == 0, "R5 core waits", 64'(core_inj_ack), 0);
    @(posedge clk); #1;
    chk(ring_out_data == rf, "R5 ring wins", 64'(ring_out_data), 64'(rf));
    @(negedge clk);
    ring_in_req = 0;
    #4 chk(core_inj_ack == 0, "R8 core below mesh", 64'(core_inj_ack), 0);
    @(posedge clk); #1;
    chk(ring_out_data == mf, "R7 single vc served", 64'(ring_out_data), 64'(mf));
    @(negedge clk);
    #4 chk(core_inj_ack == 1, "R8 core granted", 64'(core_inj_ack), 1);
    @(posedge clk); #1;
    chk(ring_out_req == 1 && ring_out_data == cf, "R8 core forwarded",
        64'(ring_out_data), 64'(cf));
    chk(eject_valid == 0, "R8 core not ejected", 64'(eject_valid), 0);
    @(negedge clk) core_inj_req = 0;
    @(posedge clk); #1;
    chk(ring_out_req == 0, "R8 idle", 64'(ring_out_req), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule